// File: doc/BRIEF.md
# DRAM Refresh Row Address Generator

This block builds the 20-bit physical address that the bus interface drives during every DRAM refresh bus cycle, and keeps a single flag that says whether a refresh is waiting to be run. A refresh interval timer pulses a strobe. The strobe raises the pending flag. The bus interface runs the refresh cycle and then pulses a completion signal. That completion lowers the flag and moves the row counter on by one step.

The address has three parts. The seven top bits come from a base register that software writes. The twelve middle bits come from a shift-register row counter. This counter is a linear-feedback design with an extra correction term, so it passes through all 4096 row values, the all-zeros value among them. The lowest bit is always one. The counter is not binary, so rows are refreshed out of numeric order. Only the refresh interval matters to the DRAM, and every row is still visited once per period.

Requests are not queued. A strobe that comes while a refresh is already waiting is merged into it, and the block reports it on a one-cycle drop pulse so it can be counted elsewhere. The address does not move while a request waits, so the bus interface can sample it at any point.

Top module: `rfsh_addr_gen`

## Requirements
- R1: After reset `rfsh_req_o` is 0, `drop_o` is 0, the row counter holds 12'h000, the base register holds 0, and so `rfsh_addr_o` is 20'h00001.
- R2: `rfsh_addr_o[0]` is always 1. `rfsh_addr_o[12:1]` is the row counter value. `rfsh_addr_o[19:13]` is the presented base value.
- R3: The row counter steps as next = {s[10:0], b}, where b is the parity of the bits s[11], s[5], s[3] and s[0], inverted when s[10:0] is all zeros. From 12'h000 the first step gives 12'h001. Over 4096 steps every 12-bit value appears exactly once, and the counter then returns to its start value.
- R4: The row counter takes exactly one step on each clock edge at which `rfsh_done_i` is high while `rfsh_req_o` is high. At any other time `rfsh_done_i` has no effect, and this includes the case where no request is pending.
- R5: `rfsh_req_o` goes high on the edge after `tick_i` is high. It goes low on the edge after `rfsh_done_i` is high. When `tick_i` and `rfsh_done_i` are both high at the same edge, `rfsh_req_o` stays high.
- R6: `drop_o` is high for exactly the one cycle after an edge at which `tick_i` is high, `rfsh_req_o` is already high and `rfsh_done_i` is low. Otherwise it is 0. A merged request still produces only one row step.
- R7: While `rfsh_req_o` is high and `rfsh_done_i` is low, `rfsh_addr_o` holds its value from one edge to the next, even when the base register is written.
- R8: `base_we_i` loads `base_data_i` into the base register. When no request is pending the new value reaches `rfsh_addr_o[19:13]` two edges after the write. A write made while a request is pending reaches the address one edge after `rfsh_req_o` falls. Base writes never change the row counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Refresh request strobe from the interval timer |
| rfsh_done_i | input | 1 | Bus interface reports that a refresh bus cycle has completed |
| base_we_i | input | 1 | Write enable for the base register |
| base_data_i | input | 7 | Value written to the base register |
| rfsh_req_o | output | 1 | Refresh request pending |
| drop_o | output | 1 | One-cycle pulse when a request is merged into one already pending |
| rfsh_addr_o | output | 20 | Refresh physical address |

## Verification
A bad row-counter state shows up at `rfsh_addr_o[12:1]` straight after the completion that caused it. A counter that skips the all-zeros value, or falls into a short cycle, repeats a value within one sweep of 4096 refreshes. The bench finds this because it tracks every value it has seen. A fault in the pending flag shows at `rfsh_req_o` or `drop_o` on the first edge after the strobe or the completion. A base value that is latched at the wrong time moves `rfsh_addr_o[19:13]` while a request is still waiting, one edge after the write.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  localparam int unsigned RFSH_ROW_W  = 12;
  localparam int unsigned RFSH_BASE_W = 7;

  // Feedback taps for x^12 + x^6 + x^4 + x + 1 on a left-shifting register
  localparam logic [RFSH_ROW_W-1:0] RFSH_ROW_TAPS = 12'h829;

  typedef enum logic {
    RQ_IDLE = 1'b0,
    RQ_WAIT = 1'b1
  } rq_state_e;

endpackage

// File: rtl/rfsh_row_lfsr.sv
module rfsh_row_lfsr #(
  parameter int unsigned      W           = 12,
  parameter logic [W-1:0]     TAPS        = 12'h829,
  parameter logic [W-1:0]     SEED        = '0,
  parameter bit               FULL_PERIOD = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] row_o
);

  logic [W-1:0] row_q;
  logic [W-1:0] row_next;

  function automatic logic tap_parity(input logic [W-1:0] s);
    return ^(s & TAPS);
  endfunction

  generate
    if (FULL_PERIOD) begin : g_full
      // correction term lets the register pass through and leave all-zeros
      function automatic logic [W-1:0] step(input logic [W-1:0] s);
        logic fb;
        fb = tap_parity(s) ^ (~|s[W-2:0]);
        return {s[W-2:0], fb};
      endfunction
      assign row_next = step(row_q);
    end else begin : g_plain
      function automatic logic [W-1:0] step(input logic [W-1:0] s);
        return {s[W-2:0], tap_parity(s)};
      endfunction
      assign row_next = step(row_q);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     row_q <= SEED;
    else if (adv_i) row_q <= row_next;
  end

  assign row_o = row_q;

endmodule

// File: rtl/rfsh_req_track.sv
module rfsh_req_track
  import rfsh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic done_i,
  output logic pend_o,
  output logic adv_o,
  output logic drop_evt_o,
  output logic drop_o
);

  rq_state_e state_q;
  rq_state_e state_d;
  logic      drop_q;
  logic      pend;

  assign pend       = (state_q == RQ_WAIT);
  assign adv_o      = pend & done_i;
  assign drop_evt_o = pend & tick_i & ~done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RQ_IDLE: if (tick_i) state_d = RQ_WAIT;
      RQ_WAIT: if (done_i && !tick_i) state_d = RQ_IDLE;
      default: state_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RQ_IDLE;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      drop_q  <= drop_evt_o;
    end
  end

  assign pend_o = pend;
  assign drop_o = drop_q;

endmodule

// File: rtl/rfsh_addr_asm.sv
module rfsh_addr_asm #(
  parameter int unsigned BASE_W = 7,
  parameter int unsigned ROW_W  = 12,
  localparam int unsigned ADDR_W = BASE_W + ROW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [BASE_W-1:0] wdata_i,
  input  logic              hold_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [BASE_W-1:0] base_q;
  logic [BASE_W-1:0] shown_q;

  function automatic logic [ADDR_W-1:0] pack_addr(input logic [BASE_W-1:0] b,
                                                   input logic [ROW_W-1:0]  r);
    return {b, r, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (we_i) base_q <= wdata_i;
  end

  // presented base only follows the register while no request waits
  always_ff @(posedge clk) begin
    if (!rst_n) shown_q <= '0;
    else if (!hold_i) shown_q <= base_q;
  end

  assign addr_o = pack_addr(shown_q, row_i);

endmodule

// File: rtl/rfsh_addr_gen.sv
module rfsh_addr_gen
  import rfsh_pkg::*;
#(
  parameter int unsigned BASE_W = RFSH_BASE_W,
  parameter int unsigned ROW_W  = RFSH_ROW_W,
  parameter logic [ROW_W-1:0] ROW_TAPS = RFSH_ROW_TAPS,
  localparam int unsigned ADDR_W = BASE_W + ROW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rfsh_done_i,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_data_i,
  output logic              rfsh_req_o,
  output logic              drop_o,
  output logic [ADDR_W-1:0] rfsh_addr_o
);

  logic             pend;
  logic             adv_evt;
  logic             drop_evt;
  logic [ROW_W-1:0] row;

  rfsh_req_track u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .done_i     (rfsh_done_i),
    .pend_o     (pend),
    .adv_o      (adv_evt),
    .drop_evt_o (drop_evt),
    .drop_o     (drop_o)
  );

  rfsh_row_lfsr #(
    .W           (ROW_W),
    .TAPS        (ROW_TAPS),
    .SEED        ('0),
    .FULL_PERIOD (1'b1)
  ) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .adv_i (adv_evt),
    .row_o (row)
  );

  rfsh_addr_asm #(
    .BASE_W (BASE_W),
    .ROW_W  (ROW_W)
  ) u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (base_we_i),
    .wdata_i (base_data_i),
    .hold_i  (pend),
    .row_i   (row),
    .addr_o  (rfsh_addr_o)
  );

  assign rfsh_req_o = pend;

endmodule

// File: rtl/rfsh_addr_gen_chk.sv
module rfsh_addr_gen_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              rfsh_done_i,
  input logic              rfsh_req_o,
  input logic              drop_o,
  input logic [ADDR_W-1:0] rfsh_addr_o,
  input logic              adv_evt,
  input logic              drop_evt
);

  AST_ADDR_LSB_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_addr_o[0]); // R2

  AST_REQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> rfsh_req_o); // R5

  AST_REQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req_o && rfsh_done_i && !tick_i) |=> !rfsh_req_o); // R5

  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> drop_o); // R6

  AST_DROP_ONLY_ON_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_i && rfsh_req_o && !rfsh_done_i) |=> !drop_o); // R6

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_req_o && !rfsh_done_i) |=> $stable(rfsh_addr_o)); // R7

  AST_ROW_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rfsh_req_o |=> $stable(rfsh_addr_o[ADDR_W-8:1])); // R4

  AST_ROW_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    adv_evt |=> !$stable(rfsh_addr_o[ADDR_W-8:1])); // R3

endmodule

bind rfsh_addr_gen rfsh_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_i      (tick_i),
  .rfsh_done_i (rfsh_done_i),
  .rfsh_req_o  (rfsh_req_o),
  .drop_o      (drop_o),
  .rfsh_addr_o (rfsh_addr_o),
  .adv_evt     (adv_evt),
  .drop_evt    (drop_evt)
);

// File: tb/rfsh_addr_gen_bench.sv
`timescale 1ns/1ps
module rfsh_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        rfsh_done_i = 1'b0;
  logic        base_we_i = 1'b0;
  logic [6:0]  base_data_i = '0;
  logic        rfsh_req_o;
  logic        drop_o;
  logic [19:0] rfsh_addr_o;

  int n_checks = 0;
  int n_bad = 0;
  logic [11:0] row_exp;
  logic [6:0]  base_exp;
  bit seen [4096];

  always #5 clk = ~clk;

  rfsh_addr_gen u_rfsh_addr_gen (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .rfsh_done_i(rfsh_done_i),
    .base_we_i(base_we_i), .base_data_i(base_data_i),
    .rfsh_req_o(rfsh_req_o), .drop_o(drop_o), .rfsh_addr_o(rfsh_addr_o)
  );

  function automatic logic [11:0] model_step(input logic [11:0] s);
    int  ones;
    logic b;
    ones = $countones(s & 12'b1000_0010_1001);
    b = (ones % 2 == 1);
    if (s[10:0] == 11'd0) b = ~b;
    return {s[10:0], b};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check_addr(input string tag);
    logic [19:0] e;
    e = {base_exp, row_exp, 1'b1};
    check(rfsh_addr_o == e, tag, 32'(rfsh_addr_o), 32'(e));
  endtask

  // one request followed by one completion
  task automatic one_refresh(input string tag);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    check(rfsh_req_o == 1'b1, {tag, " R5 set"}, 32'(rfsh_req_o), 1);
    rfsh_done_i = 1'b1; cyc(); rfsh_done_i = 1'b0;
    row_exp = model_step(row_exp);
    check(rfsh_req_o == 1'b0, {tag, " R5 clear"}, 32'(rfsh_req_o), 0);
    check_addr({tag, " R3 R4 row step"});
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    n_checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_bad, n_checks);
    $finish;
  end

  initial begin
    row_exp = 12'h000;
    base_exp = 7'h00;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    check(rfsh_req_o == 1'b0, "R1 req after reset", 32'(rfsh_req_o), 0);
    check(drop_o == 1'b0, "R1 drop after reset", 32'(drop_o), 0);
    check(rfsh_addr_o == 20'h00001, "R1 addr after reset", 32'(rfsh_addr_o), 32'h1);

    // R4 completion with nothing pending is ignored
    rfsh_done_i = 1'b1; cyc(); cyc(); rfsh_done_i = 1'b0;
    check_addr("R4 idle done ignored");
    check(rfsh_req_o == 1'b0, "R4 idle done req", 32'(rfsh_req_o), 0);

    // R3 first step from zero
    one_refresh("first");
    check(rfsh_addr_o[12:1] == 12'h001, "R3 first step", 32'(rfsh_addr_o[12:1]), 32'h1);

    // R8 base write while idle: visible after two edges, row untouched
    base_data_i = 7'h5A; base_we_i = 1'b1; cyc(); base_we_i = 1'b0;
    cyc();
    base_exp = 7'h5A;
    check_addr("R8 idle base write");
    check(rfsh_addr_o[0] == 1'b1, "R2 lsb", 32'(rfsh_addr_o[0]), 1);

    // R6 merge: second strobe while pending
    tick_i = 1'b1; cyc();
    check(drop_o == 1'b0, "R6 no drop on first strobe", 32'(drop_o), 0);
    cyc(); tick_i = 1'b0;
    check(drop_o == 1'b1, "R6 drop on merged strobe", 32'(drop_o), 1);
    cyc();
    check(drop_o == 1'b0, "R6 drop one cycle", 32'(drop_o), 0);
    check(rfsh_req_o == 1'b1, "R6 still pending", 32'(rfsh_req_o), 1);

    // R7 base write during pending leaves address alone
    base_data_i = 7'h13; base_we_i = 1'b1; cyc(); base_we_i = 1'b0;
    cyc(); cyc();
    check_addr("R7 addr held while pending");
    rfsh_done_i = 1'b1; cyc(); rfsh_done_i = 1'b0;
    row_exp = model_step(row_exp);
    check_addr("R6 single step for merged requests");
    cyc();
    base_exp = 7'h13;
    check_addr("R8 deferred base write");
    check(rfsh_req_o == 1'b0, "R6 merged request fully served", 32'(rfsh_req_o), 0);

    // R5 strobe and completion together keep the flag
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    tick_i = 1'b1; rfsh_done_i = 1'b1; cyc(); tick_i = 1'b0; rfsh_done_i = 1'b0;
    row_exp = model_step(row_exp);
    check(rfsh_req_o == 1'b1, "R5 simultaneous keeps req", 32'(rfsh_req_o), 1);
    check(drop_o == 1'b0, "R6 no drop when served", 32'(drop_o), 0);
    check_addr("R4 step on simultaneous");
    rfsh_done_i = 1'b1; cyc(); rfsh_done_i = 1'b0;
    row_exp = model_step(row_exp);
    check_addr("R4 step after simultaneous");

    // R3 full sweep: restart from reset, 4096 refreshes, every value once
    rst_n = 1'b0; cyc(); rst_n = 1'b1;
    row_exp = 12'h000; base_exp = 7'h00;
    check_addr("R1 addr after second reset");
    for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
    begin
      int dup;
      dup = 0;
      for (int i = 0; i < 4096; i++) begin
        if (seen[rfsh_addr_o[12:1]]) dup++;
        seen[rfsh_addr_o[12:1]] = 1'b1;
        one_refresh("sweep");
      end
      check(dup == 0, "R3 no repeated row in period", 32'(dup), 0);
    end
    begin
      int missing;
      missing = 0;
      for (int i = 0; i < 4096; i++) if (!seen[i]) missing++;
      check(missing == 0, "R3 every row visited", 32'(missing), 0);
    end
    check(rfsh_addr_o[12:1] == 12'h000, "R3 period returns to start",
          32'(rfsh_addr_o[12:1]), 0);

    $display("%0d/%0d checks passed", n_checks - n_bad, n_checks);
    $finish;
  end

endmodule